// File: doc/BRIEF.md
# Entropy Block Output and Alarm Status Interface

This block is the register side of a true random number generator. A single-bit entropy stream is gathered into a bank of output words. When the bank is full, and a programmable minimum number of cycles has passed since the previous bank was released, a ready flag is raised. Software reads the words and then writes one to the ready flag. That releases the bank, and the next one starts to fill. While the flag stands, the words are frozen.

Alarm pulses from the external health tests are collected in a write-one-to-clear status register. The block also raises its own alarm when a completed bank repeats the previous completed bank exactly. Each alarm bit has an interrupt enable. A test mode lets software load the output words directly over the bus. Access uses a word-addressed bus with a combinational read path.

Top module: `trng_if`

## Requirements
- R1: After reset, every register reads zero, the generator is off and `irq` is low.
- R2: The word-address map is: 0..3 output words, 4 status, 5 control, 6 config. Control keeps only bit 10 (generator on), bit 8 (test mode) and bits 7:1 (interrupt enables). Config keeps bits 31:16 (maximum refill count) and bits 7:0 (minimum refill count). Every other bit reads zero, and so does every word address above 6.
- R3: With the generator on and test mode off, each cycle with `ent_valid` high shifts `ent_bit` into bit 0 of word 0. The 128-bit bank moves up one place, so bit 31 of word i moves to bit 0 of word i+1. Once 128 bits have been taken, status bit 0 (ready) is set.
- R4: After ready is cleared, ready is not set again until at least the minimum refill count of cycles has elapsed, even when all 128 bits arrived sooner.
- R5: While ready is set, entropy input does not change the output words.
- R6: Writing a status word clears every bit written as one and keeps every bit written as zero. Clearing bit 0 releases the bank for a new fill.
- R7: A completed bank equal to the previous completed bank sets status bit 2 (stuck) together with ready. The first bank after reset never does.
- R8: Pulses on `alarm_evt` bits 1 and 3..7 set the status bits of the same index. Those bits stay set until cleared by a write. `alarm_evt` bits 0 and 2 have no effect.
- R9: `irq` is high exactly when some status bit k in 1..7 is set together with control bit k. Ready alone never raises it.
- R10: With control bit 10 clear, no entropy is taken and ready is not set.
- R11: In test mode, bus writes to word addresses 0..3 load that word, and entropy is ignored. Outside test mode, writes to those addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read, zero otherwise |
| ent_valid | input | 1 | Entropy bit valid |
| ent_bit | input | 1 | Entropy bit |
| alarm_evt | input | 8 | Health-test alarm pulses, aligned to status bits |
| irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that bus accesses last one cycle, with `bus_we` steady for the access, and that no status write aimed at a bit coincides with an alarm pulse on that bit. They also assume alarm pulses arrive as single-cycle levels. The stimulus keeps to these rules: accesses are separated by idle cycles, and alarms are pulsed only while no status write is in flight. Entropy is fed in blocks of exactly 128 valid bits after each release. This keeps the expected bank fully known to the bench.

// File: rtl/trng_pkg.sv
package trng_pkg;
  // status bit positions (software decodes these)
  localparam int ST_W      = 8;
  localparam int ST_READY  = 0;
  localparam int ST_SHUTDN = 1;
  localparam int ST_STUCK  = 2;
  localparam int ST_NOISE  = 3;
  localparam int ST_RUN    = 4;
  localparam int ST_LRUN   = 5;
  localparam int ST_POKER  = 6;
  localparam int ST_MONO   = 7;
  // alarm inputs that may set status directly (ready and stuck are internal)
  localparam logic [ST_W-1:0] EXT_EVT_MASK = 8'hFA;

  // control field positions
  localparam int CT_W    = 11;
  localparam int CT_EN   = 10;
  localparam int CT_TEST = 8;
  localparam logic [CT_W-1:0] CT_KEEP = 11'h5FE;

  // config field widths
  localparam int MAXF_W = 16;
  localparam int MINF_W = 8;

  // word offsets of the non-data registers
  localparam int OFS_STAT = 4;
  localparam int OFS_CTRL = 5;
  localparam int OFS_CFG  = 6;
endpackage

// File: rtl/trng_rst_sync.sv
module trng_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/trng_collector.sv
module trng_collector
  import trng_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int CNT_W   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en_i,
  input  logic                            test_i,
  input  logic                            ready_i,
  input  logic [CNT_W-1:0]                min_cyc_i,
  input  logic                            ent_valid_i,
  input  logic                            ent_bit_i,
  input  logic                            tw_en_i,
  input  logic [((N_WORDS>1)?$clog2(N_WORDS):1)-1:0] tw_idx_i,
  input  logic [WORD_W-1:0]               tw_data_i,
  output logic [WORD_W*N_WORDS-1:0]       blk_o,
  output logic                            done_o,
  output logic                            stuck_o
);
  localparam int BLK_W  = WORD_W * N_WORDS;
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int BCNT_W = $clog2(BLK_W + 1);

  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [BLK_W-1:0]  prev_q, prev_d;
  logic              have_prev_q, have_prev_d;
  logic [BCNT_W-1:0] bits_q, bits_d;
  logic [CNT_W-1:0]  cyc_q, cyc_d;

  logic run, full, take, done, tw_act;

  // ---------------- next state ----------------
  always_comb begin
    run    = en_i && !test_i && !ready_i;
    full   = (bits_q == BCNT_W'(BLK_W));
    take   = run && ent_valid_i && !full;
    done   = run && full && (cyc_q >= min_cyc_i);
    tw_act = tw_en_i && test_i;

    blk_d = blk_q;
    if (take) begin
      blk_d = {blk_q[BLK_W-2:0], ent_bit_i};
    end else if (tw_act) begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (tw_idx_i == IDX_W'(i)) blk_d[i*WORD_W +: WORD_W] = tw_data_i;
      end
    end

    if (!run || done)  bits_d = '0;
    else if (take)     bits_d = bits_q + 1'b1;
    else               bits_d = bits_q;

    if (!run)               cyc_d = '0;
    else if (cyc_q == '1)   cyc_d = cyc_q;
    else                    cyc_d = cyc_q + 1'b1;

    prev_d      = done ? blk_q : prev_q;
    have_prev_d = have_prev_q || done;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q       <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      bits_q      <= '0;
      cyc_q       <= '0;
    end else begin
      if (take || tw_act) blk_q <= blk_d;
      if (done) begin
        prev_q      <= prev_d;
        have_prev_q <= have_prev_d;
      end
      bits_q <= bits_d;
      cyc_q  <= cyc_d;
    end
  end

  assign blk_o   = blk_q;
  assign done_o  = done;
  assign stuck_o = done && have_prev_q && (blk_q == prev_q);

  // ---------------- assertions ----------------
  // R5: bank frozen while ready stands (test writes excepted)
  a_r5_hold_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && !tw_act) |=> $stable(blk_o));

  // R10: generator off leaves the bank untouched
  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !tw_act) |=> $stable(blk_o));

  // R4: a release is never followed at once by a completion
  a_r4_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_i) |=> !done_o);
endmodule

// File: rtl/trng_status.sv
module trng_status
  import trng_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_i,
  input  logic            w1c_en_i,
  input  logic [ST_W-1:0] w1c_mask_i,
  input  logic [ST_W-1:0] irq_en_i,
  output logic [ST_W-1:0] stat_o,
  output logic            irq_o
);
  localparam logic [ST_W-1:0] IRQ_SRC = ~(ST_W'(1) << ST_READY);

  logic [ST_W-1:0] stat_q, stat_d, clr;

  always_comb begin
    clr    = w1c_en_i ? w1c_mask_i : '0;
    stat_d = (stat_q & ~clr) | set_i;   // a new event wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & irq_en_i & IRQ_SRC);

  // R6: bits written as one are gone next cycle unless re-raised
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_en_i |=> ((stat_q & $past(w1c_mask_i) & ~$past(set_i)) == '0));

  // R8: without a status write no bit ever drops
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !w1c_en_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R9: nothing raised in bits 7:1 means no interrupt
  a_r9_ready_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[ST_W-1:1] == '0) |-> !irq_o);
endmodule

// File: rtl/trng_if.sv
module trng_if
  import trng_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ent_valid,
  input  logic              ent_bit,
  input  logic [ST_W-1:0]   alarm_evt,
  output logic              irq
);
  localparam int BLK_W = WORD_W * N_WORDS;
  localparam int IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic rst_i_n;

  logic [CT_W-1:0]   ctrl_q, ctrl_d;
  logic [MAXF_W-1:0] cfg_max_q, cfg_max_d;
  logic [MINF_W-1:0] cfg_min_q, cfg_min_d;

  logic wr, wr_ctrl, wr_cfg, wr_stat, wr_word;
  logic [BLK_W-1:0]  blk;
  logic              done, stuck;
  logic [ST_W-1:0]   set_vec, stat;
  logic [WORD_W-1:0] rd_mux;

  trng_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // ---------------- decode ----------------
  always_comb begin
    wr      = bus_sel && bus_we;
    wr_stat = wr && (bus_addr == ADDR_W'(OFS_STAT));
    wr_ctrl = wr && (bus_addr == ADDR_W'(OFS_CTRL));
    wr_cfg  = wr && (bus_addr == ADDR_W'(OFS_CFG));
    wr_word = wr && (bus_addr < ADDR_W'(N_WORDS));
  end

  // ---------------- control / config ----------------
  always_comb begin
    ctrl_d    = bus_wdata[CT_W-1:0] & CT_KEEP;
    cfg_max_d = bus_wdata[WORD_W-1 -: MAXF_W];
    cfg_min_d = bus_wdata[MINF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q    <= '0;
      cfg_max_q <= '0;
      cfg_min_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_cfg) begin
        cfg_max_q <= cfg_max_d;
        cfg_min_q <= cfg_min_d;
      end
    end
  end

  // ---------------- bank fill ----------------
  trng_collector #(
    .WORD_W  (WORD_W),
    .N_WORDS (N_WORDS),
    .CNT_W   (MINF_W)
  ) u_col (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .en_i        (ctrl_q[CT_EN]),
    .test_i      (ctrl_q[CT_TEST]),
    .ready_i     (stat[ST_READY]),
    .min_cyc_i   (cfg_min_q),
    .ent_valid_i (ent_valid),
    .ent_bit_i   (ent_bit),
    .tw_en_i     (wr_word),
    .tw_idx_i    (bus_addr[IDX_W-1:0]),
    .tw_data_i   (bus_wdata),
    .blk_o       (blk),
    .done_o      (done),
    .stuck_o     (stuck)
  );

  // ---------------- status ----------------
  always_comb begin
    set_vec           = alarm_evt & EXT_EVT_MASK;
    set_vec[ST_READY] = done;
    set_vec[ST_STUCK] = stuck;
  end

  trng_status u_st (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .set_i      (set_vec),
    .w1c_en_i   (wr_stat),
    .w1c_mask_i (bus_wdata[ST_W-1:0]),
    .irq_en_i   ({ctrl_q[ST_W-1:1], 1'b0}),
    .stat_o     (stat),
    .irq_o      (irq)
  );

  // ---------------- read path ----------------
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_WORDS; i++) begin
      if (bus_addr == ADDR_W'(i)) rd_mux = blk[i*WORD_W +: WORD_W];
    end
    if (bus_addr == ADDR_W'(OFS_STAT)) rd_mux = WORD_W'(stat);
    if (bus_addr == ADDR_W'(OFS_CTRL)) rd_mux = WORD_W'(ctrl_q);
    if (bus_addr == ADDR_W'(OFS_CFG))
      rd_mux = {cfg_max_q, {(WORD_W-MAXF_W-MINF_W){1'b0}}, cfg_min_q};
  end

  assign bus_rdata = (bus_sel && !bus_we) ? rd_mux : '0;

  // R7: the stuck flag only appears together with a fresh ready
  a_r7_stuck_with_ready: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(stat[ST_STUCK]) |-> $rose(stat[ST_READY]));

  // R2: addresses past the config word read as zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && !bus_we && (bus_addr > ADDR_W'(OFS_CFG))) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_trng_if.sv
module sim_trng_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ent_valid = 1'b0, ent_bit = 1'b0;
  logic [7:0]  alarm_evt = '0;
  logic        irq;

  int checks = 0, failures = 0;
  int cyc = 0;
  bit peeking = 1'b0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t expq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trng_if u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_valid(ent_valid), .ent_bit(ent_bit), .alarm_evt(alarm_evt), .irq(irq)
  );

  task automatic report;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results and compares
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_we && !peeking) begin
      if (expq.size() == 0) begin
        check("monitor unexpected read", 32'h1, 32'h0);
      end else begin
        rd_item_t it;
        it = expq.pop_front();
        check(it.tag, bus_rdata, it.exp);
        check({it.tag, " addr"}, {28'h0, bus_addr}, {28'h0, it.addr});
      end
    end
  end

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, logic [31:0] e, string tag);
    rd_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    expq.push_back(it);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    peeking = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; peeking = 1'b0;
  endtask

  // first bit sent ends in bank bit 127, so the bank equals v
  task automatic feed(logic [127:0] v, int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      ent_valid = 1'b1; ent_bit = v[127-i];
    end
    @(posedge clk); #1;
    ent_valid = 1'b0;
  endtask

  task automatic wait_ready(string tag, output int at);
    logic [31:0] s;
    s = '0;
    for (int k = 0; k < 2000; k++) begin
      peek(4'd4, s);
      if (s[0]) break;
    end
    at = cyc;
    check({tag, " ready seen"}, {31'h0, s[0]}, 32'h1);
  endtask

  task automatic read_bank(logic [127:0] v, string tag);
    for (int w = 0; w < 4; w++) bus_read(4'(w), v[32*w +: 32], tag);
  endtask

  task automatic pulse(logic [7:0] v);
    @(posedge clk); #1; alarm_evt = v;
    @(posedge clk); #1; alarm_evt = '0;
  endtask

  task automatic check_irq(string tag, logic e);
    @(negedge clk);
    check(tag, {31'h0, irq}, {31'h0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [127:0] blk_a, blk_b, blk_c;
    int rel, rdy;
    blk_a = 128'h0BAD_BEEF_CAFE_F00D_1234_5678_A5A5_0F0F;
    blk_b = 128'h1357_9BDF_2468_ACE0_FEDC_BA98_0011_2233;
    blk_c = 128'hFFFF_0000_FFFF_0000_5555_AAAA_3333_CCCC;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) bus_read(4'(a), 32'h0, "R1 reset value");
    check_irq("R1 irq after reset", 1'b0);

    // R2 field masks and unmapped space
    bus_write(4'd5, 32'hFFFF_FFFF);
    bus_read(4'd5, 32'h0000_05FE, "R2 control kept bits");
    bus_write(4'd5, 32'h0);
    bus_write(4'd6, 32'hFFFF_FFFF);
    bus_read(4'd6, 32'hFFFF_00FF, "R2 config kept bits");
    for (int a = 7; a < 16; a++) bus_read(4'(a), 32'h0, "R2 unmapped read");

    // R10 generator off
    bus_write(4'd6, 32'h00AB_000A);
    feed(blk_a, 128);
    repeat (20) @(posedge clk);
    bus_read(4'd4, 32'h0, "R10 no ready while off");
    bus_read(4'd0, 32'h0, "R10 word untouched while off");

    // R3 fill, R9 ready alone no irq
    bus_write(4'd5, 32'h0000_04FE);
    feed(blk_a, 128);
    wait_ready("R3", rdy);
    bus_read(4'd4, 32'h1, "R3 status ready only");
    read_bank(blk_a, "R3 bank word");
    check_irq("R9 ready alone", 1'b0);

    // R5 entropy ignored while ready
    feed(blk_c, 128);
    read_bank(blk_a, "R5 bank held");

    // R11 word write ignored outside test mode
    bus_write(4'd0, 32'h1234_5678);
    bus_read(4'd0, blk_a[31:0], "R11 word write ignored");

    // R4 minimum refill, R6 release
    bus_write(4'd6, 32'h00AB_0096);
    bus_write(4'd4, 32'h1);
    rel = cyc;
    bus_read(4'd4, 32'h0, "R6 ready cleared");
    feed(blk_b, 128);
    wait_ready("R4", rdy);
    check("R4 cycles release to ready", 32'(rdy - rel) >= 150 ? 32'h1 : 32'h0, 32'h1);
    read_bank(blk_b, "R3 second bank word");
    bus_read(4'd4, 32'h1, "R7 different bank no stuck");

    // R7 repeated bank
    bus_write(4'd4, 32'h1);
    feed(blk_b, 128);
    wait_ready("R7", rdy);
    bus_read(4'd4, 32'h5, "R7 stuck with ready");
    check_irq("R9 stuck raises irq", 1'b1);
    bus_write(4'd4, 32'h4);
    bus_read(4'd4, 32'h1, "R6 only written bit cleared");
    check_irq("R9 irq gone after clear", 1'b0);

    // R8 alarm inputs
    pulse(8'h08);
    bus_read(4'd4, 32'h9, "R8 noise alarm latched");
    check_irq("R9 enabled alarm", 1'b1);
    bus_write(4'd5, 32'h0000_04F6);
    check_irq("R9 masked alarm", 1'b0);
    bus_read(4'd4, 32'h9, "R9 status kept when masked");
    pulse(8'h05);
    bus_read(4'd4, 32'h9, "R8 bits 0 and 2 no effect");
    pulse(8'hFA);
    bus_read(4'd4, 32'hFB, "R8 all external alarms");
    bus_write(4'd4, 32'hFF);
    bus_read(4'd4, 32'h0, "R6 clear all");

    // R11 test mode
    bus_write(4'd5, 32'h0000_0100);
    bus_write(4'd2, 32'hDEAD_BEEF);
    bus_read(4'd2, 32'hDEAD_BEEF, "R11 test write loads word");
    feed(blk_c, 16);
    bus_read(4'd0, blk_b[31:0], "R11 entropy ignored in test");
    bus_read(4'd4, 32'h0, "R11 no ready in test");

    repeat (2) @(posedge clk);
    report();
  end
endmodule